// File: doc/BRIEF.md
# Shared-Port Multicycle Instruction Sequencer

This block is the control state machine of a small 32-bit load/store processor. Instruction fetch and data access use the same memory port. That port works by handshake: a one-cycle start pulse, then a done pulse that can come any number of cycles later. Each instruction steps through a fixed sequence of phases:

1. Issue a fetch, wait for the word, and latch it into the instruction register.
2. Spend one execute cycle.
3. For loads and stores only: issue a data access and wait for it. A load then spends one more cycle writing the register file.

The block keeps the program counter and the instruction register. It drives the handshake, the read/write select, the address-source select, the instruction-register load, the PC write enable and the register-file write enable. The ALU and the register file sit outside the block. The ALU result arrives on `alu_addr`, and branch decisions arrive on `br_taken` and `br_target`.

Because each instruction takes a variable number of cycles, the PC changes only once per completed instruction.

Top module: `mc_sequencer`

## Requirements
- R1: While reset is active and just after it, `phase` is 0 (fetch issue), `pc` is 0 and `mem_go` is 0 during reset.
- R2: `mem_go` pulses for exactly one cycle per memory operation: one fetch per instruction, plus one data access for each load and store.
- R3: `addr_sel` is 0 and `mem_addr` equals `pc` during fetch phases. `addr_sel` is 1 and `mem_addr` equals `alu_addr` during data phases. `addr_sel` and `mem_we` stay stable while a wait is in progress.
- R4: When `mem_finished` arrives during the fetch wait, `ir` takes `mem_rdata` and then holds it for the rest of the instruction.
- R5: Instructions other than loads and stores take L+2 cycles, where L is the number of cycles from the cycle after `mem_go` up to and including the `mem_finished` cycle.
- R6: A load takes L1+L2+4 cycles and a store takes L1+L2+3 cycles. L1 is the fetch latency and L2 is the data latency.
- R7: `pc_we` is high for exactly one cycle per instruction, in the final cycle of that instruction. `pc` then becomes `pc+4`, or `br_target` for a branch with `br_taken` high.
- R8: `rf_we` is high for exactly one cycle for an ALU instruction (in execute) and for a load (in write-back). It is never high for a store or a branch.
- R9: A load places the `mem_rdata` word returned with its data `mem_finished` on `ld_data`. `ld_data` keeps that value until the next load.
- R10: `mem_we` is 1 with the data `mem_go` of a store. It is 0 for every fetch and every load.
- R11: The instruction class is read from `ir[31:30]`: 00 is ALU, 01 is load, 10 is store and 11 is branch.
- R12: The phase encoding on `phase` is 0 fetch issue, 1 fetch wait, 2 execute, 3 memory issue, 4 memory wait and 5 write-back. The machine is back in phase 0 in the cycle after `pc_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_finished | input | 1 | Memory done pulse |
| mem_rdata | input | 32 | Memory read word, valid with `mem_finished` |
| alu_addr | input | 32 | ALU result used as the data address |
| br_taken | input | 1 | Branch condition, sampled in execute |
| br_target | input | 32 | Branch destination |
| mem_go | output | 1 | One-cycle start of a memory operation |
| mem_we | output | 1 | Memory write select |
| addr_sel | output | 1 | Address source: 0 is PC, 1 is ALU result |
| mem_addr | output | 32 | Memory address |
| ir_load | output | 1 | Instruction register capture strobe |
| ir | output | 32 | Instruction register |
| pc_we | output | 1 | PC write enable |
| pc | output | 32 | Program counter |
| rf_we | output | 1 | Register-file write enable |
| ld_data | output | 32 | Captured load word |
| phase | output | 3 | Current phase code |

## Verification
A wrong phase shows up at the ports within one instruction. A wrong phase sends `mem_go` at the wrong time, sets `mem_we` wrongly on the data access, or changes the number of cycles between consecutive `pc_we` pulses. Any of these breaks the cycle count and pulse tally of the instruction in which it happens. A corrupted PC or instruction register shows up at the next fetch address, or in the class decoded for the next instruction. The sweep therefore covers every class under fetch and data latencies of 1 to 4 cycles, with and without a taken branch, and checks the phase, the PC and the pulse counts at every instruction boundary.

// File: rtl/mc_sequencer.sv
module mc_sequencer #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mem_finished,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic [XLEN-1:0] alu_addr,
  input  logic            br_taken,
  input  logic [XLEN-1:0] br_target,
  output logic            mem_go,
  output logic            mem_we,
  output logic            addr_sel,
  output logic [XLEN-1:0] mem_addr,
  output logic            ir_load,
  output logic [XLEN-1:0] ir,
  output logic            pc_we,
  output logic [XLEN-1:0] pc,
  output logic            rf_we,
  output logic [XLEN-1:0] ld_data,
  output logic [2:0]      phase
);
  typedef enum logic [2:0] {
    ST_FI = 3'd0, ST_FW = 3'd1, ST_EX = 3'd2,
    ST_MI = 3'd3, ST_MW = 3'd4, ST_WB = 3'd5
  } st_t;

  localparam logic [1:0] OP_ALU = 2'b00, OP_LD = 2'b01, OP_ST = 2'b10, OP_BR = 2'b11;

  st_t st, st_nx;
  logic [1:0] op;
  logic is_mem;

  assign op       = ir[XLEN-1 -: 2];
  assign is_mem   = (op == OP_LD) || (op == OP_ST);
  assign phase    = st;
  assign mem_go   = rst_n && (st == ST_FI || st == ST_MI);
  assign addr_sel = (st == ST_MI) || (st == ST_MW);
  assign mem_we   = addr_sel && (op == OP_ST);
  assign mem_addr = addr_sel ? alu_addr : pc;
  assign ir_load  = (st == ST_FW) && mem_finished;
  assign pc_we    = (st == ST_EX && !is_mem) || (st == ST_MW && mem_finished && op == OP_ST) || (st == ST_WB);
  assign rf_we    = (st == ST_EX && op == OP_ALU) || (st == ST_WB);

  always_comb begin
    st_nx = st;
    case (st)
      ST_FI: st_nx = ST_FW;
      ST_FW: if (mem_finished) st_nx = ST_EX;
      ST_EX: st_nx = is_mem ? ST_MI : ST_FI;
      ST_MI: st_nx = ST_MW;
      ST_MW: if (mem_finished) st_nx = (op == OP_LD) ? ST_WB : ST_FI;
      ST_WB: st_nx = ST_FI;
      default: st_nx = ST_FI;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_FI;
      pc      <= RESET_PC;
      ir      <= '0;
      ld_data <= '0;
    end else begin
      st <= st_nx;
      if (ir_load) ir <= mem_rdata;
      if (st == ST_MW && mem_finished && op == OP_LD) ld_data <= mem_rdata;
      if (pc_we) pc <= (st == ST_EX && op == OP_BR && br_taken) ? br_target : pc + XLEN'(4);
    end
  end
endmodule

module mc_sequencer_chk #(parameter int XLEN = 32) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_go,
  input logic            mem_we,
  input logic            addr_sel,
  input logic            ir_load,
  input logic [XLEN-1:0] ir,
  input logic            pc_we,
  input logic [XLEN-1:0] pc,
  input logic            rf_we,
  input logic [2:0]      phase
);
  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_go |=> !mem_go); // R2
  AST_GO_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n) mem_go |=> (phase == 3'd1 || phase == 3'd4)); // R12
  AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (phase == 3'd1 || phase == 3'd4) |-> ($stable(addr_sel) && $stable(mem_we))); // R3
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ir_load |=> $stable(ir)); // R4
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !pc_we |=> $stable(pc)); // R7
  AST_PC_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n) pc_we |=> phase == 3'd0); // R12
  AST_RF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rf_we |=> !rf_we); // R8
  AST_FETCH_READS: assert property (@(posedge clk) disable iff (!rst_n) (mem_go && !addr_sel) |-> !mem_we); // R10
endmodule

bind mc_sequencer mc_sequencer_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_go(mem_go), .mem_we(mem_we), .addr_sel(addr_sel),
  .ir_load(ir_load), .ir(ir), .pc_we(pc_we), .pc(pc), .rf_we(rf_we), .phase(phase)
);

// File: tb/mc_sequencer_tb.sv
module mc_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, mem_finished = 0, br_taken = 0;
  logic [31:0] mem_rdata = '0, alu_addr = '0, br_target = '0;
  logic mem_go, mem_we, addr_sel, ir_load, pc_we, rf_we;
  logic [31:0] mem_addr, ir, pc, ld_data;
  logic [2:0] phase;
  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_ld = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .mem_finished(mem_finished), .mem_rdata(mem_rdata),
    .alu_addr(alu_addr), .br_taken(br_taken), .br_target(br_target),
    .mem_go(mem_go), .mem_we(mem_we), .addr_sel(addr_sel), .mem_addr(mem_addr),
    .ir_load(ir_load), .ir(ir), .pc_we(pc_we), .pc(pc), .rf_we(rf_we),
    .ld_data(ld_data), .phase(phase)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [1:0] op, input int lat, input bit taken, input int idx);
    logic [31:0] pc0, word, exp_pc;
    int pend, cyc, gos, rfs, pcws, lat_now;
    bit done, first_go_ok, data_we, data_addr_ok, fetch_sel;
    pc0 = pc; word = {op, 30'(idx * 3 + 1)};
    alu_addr = 32'h1000_0000 + 32'(idx * 4);
    br_target = pc0 + 32'h40; br_taken = taken;
    pend = 0; cyc = 0; gos = 0; rfs = 0; pcws = 0; done = 0;
    first_go_ok = 0; data_we = 0; data_addr_ok = 0; fetch_sel = 1; lat_now = lat;
    chk(phase == 3'd0, "R12 start phase", 32'(phase), 0);
    while (!done) begin
      mem_finished = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_finished = 1;
          mem_rdata = fetch_sel ? word : ~alu_addr;
        end
      end
      #1;
      cyc++;
      if (mem_go) begin
        gos++;
        pend = lat_now;
        fetch_sel = !addr_sel;
        if (gos == 1) first_go_ok = (addr_sel == 0) && (mem_addr == pc0) && !mem_we;
        else begin
          data_we = mem_we;
          data_addr_ok = (addr_sel == 1) && (mem_addr == alu_addr);
        end
      end
      if (rf_we) rfs++;
      if (pc_we) begin pcws++; done = 1; end
      if (cyc > 100) done = 1;
      @(negedge clk);
    end
    mem_finished = 0;
    #1;
    chk(first_go_ok, "R3 fetch address from pc", mem_addr, pc0);
    chk(ir == word, "R4 ir captured", ir, word);
    chk(pcws == 1, "R7 one pc write", 32'(pcws), 1);
    exp_pc = (op == 2'b11 && taken) ? br_target : pc0 + 4;
    chk(pc == exp_pc, "R7 next pc", pc, exp_pc);
    chk(phase == 3'd0, "R12 back to fetch", 32'(phase), 0);
    chk(rfs == ((op == 2'b00 || op == 2'b01) ? 1 : 0), "R8 rf write count", 32'(rfs), 0);
    case (op)
      2'b00, 2'b11: begin
        chk(cyc == lat + 2, "R5 cycles", 32'(cyc), 32'(lat + 2));
        chk(gos == 1, "R2 go count", 32'(gos), 1);
      end
      2'b01: begin
        chk(cyc == 2*lat + 4, "R6 load cycles", 32'(cyc), 32'(2*lat + 4));
        chk(gos == 2, "R2 go count", 32'(gos), 2);
        chk(data_addr_ok && !data_we, "R10 load reads at alu_addr", 32'(data_we), 0);
        exp_ld = ~alu_addr;
      end
      default: begin
        chk(cyc == 2*lat + 3, "R6 store cycles", 32'(cyc), 32'(2*lat + 3));
        chk(gos == 2, "R2 go count", 32'(gos), 2);
        chk(data_addr_ok && data_we, "R10 store writes at alu_addr", 32'(data_we), 1);
      end
    endcase
    chk(ld_data == exp_ld, "R9 load data", ld_data, exp_ld);
    chk(op == ir[31:30], "R11 class field", 32'(ir[31:30]), 32'(op));
  endtask

  initial begin
    int idx;
    idx = 0;
    #1;
    chk(phase == 3'd0 && pc == 0 && !mem_go, "R1 reset state", pc, 0);
    repeat (3) @(negedge clk);
    chk(phase == 3'd0 && pc == 0 && !mem_go, "R1 reset held", {29'd0, phase}, 0);
    rst_n = 1;
    for (int lat = 1; lat <= 4; lat++)
      for (int o = 0; o < 4; o++)
        for (int t = 0; t < 2; t++) begin
          run_one(2'(o), lat, t[0], idx);
          idx++;
        end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule